// File: doc/BRIEF.md
# Mezzanine Bus Access Sequencer with Timeout

This block turns one host request into one or two cycles on a 16-bit mezzanine module bus. The host gives a space code, a byte address inside the slot's window, an access size, write data and a direction. The sequencer raises exactly one of three select strobes: identification, I/O or interrupt-select. It then waits for the module's acknowledge and answers with a one-cycle done pulse, the read data and a timeout flag.

All module-bus timing is paced by a module clock. This clock is produced inside the block by dividing the system clock by `CLK_DIV`. Strobes begin and end on module-clock ticks, and the acknowledge is sampled only on those ticks, so every wait state inserted by a module costs one module-clock period. A slot that never acknowledges is released after `TIMEOUT_TICKS` module-clock periods. This lets software probe empty slots. A 32-bit request is carried as two 16-bit bus cycles, low half first.

Top module: `mezz_access_seq`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_done` is 0 and no select strobe is active.
- R2: Space code 0 raises `mb_id_sel`, code 1 or 3 raises `mb_io_sel`, code 2 raises `mb_int_sel`. Never more than one strobe is high.
- R3: `mb_addr` is the 16-bit word address. For I/O it is `req_addr[7:1]`. For identification it is `req_addr[5:1]`, with the upper bits zero. For interrupt-select it is `req_addr[1]` alone, which picks request line 0 or 1.
- R4: Identification cycles always drive `mb_be` = 2'b11. Byte accesses elsewhere drive 2'b01 when `req_addr[0]`=0 and 2'b10 when it is 1. Half and word accesses drive 2'b11. Size codes: 0 byte, 1 half, 2 word.
- R5: A word access runs two bus cycles. The first is at the request's word address and carries `req_wdata[15:0]`. The second is at that address plus one and carries `req_wdata[31:16]`. Read data is returned as {second word, first word}.
- R6: Read data bits whose `mb_rdrive` bit is 0 are returned as 1.
- R7: If no acknowledge is sampled within `TIMEOUT_TICKS` module-clock periods of a strobe, the access ends with `rsp_timeout`=1 and `rsp_rdata` all ones. No further bus cycle is issued. With the defaults this is 256 × 25 system cycles.
- R8: The timeout count restarts for each bus cycle. Each half of a word access has its own full timeout window.
- R9: `rsp_done` is high for exactly one system cycle. A `req_valid` raised while an access is in progress is ignored.
- R10: The acknowledge is sampled only at module-clock ticks, every `CLK_DIV` system cycles. Each wait state therefore lengthens the access by `CLK_DIV` system cycles, and a strobe only falls right after a tick.
- R11: A byte read outside identification space returns the addressed lane in `rsp_rdata[7:0]` with the upper bits zero. The low lane `mb_rdata[7:0]` is returned for an even address and the high lane `mb_rdata[15:8]` for an odd one. Half reads return the bus word zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_write | input | 1 | 1 for write, 0 for read |
| req_space | input | 2 | 0 identification, 1/3 I/O, 2 interrupt-select |
| req_size | input | 2 | 0 byte, 1 half, 2 word |
| req_addr | input | 8 | Byte address inside the slot window |
| req_wdata | input | 32 | Write data, lanes already placed by the host |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_timeout | output | 1 | Completion was a timeout |
| rsp_rdata | output | 32 | Read result |
| mb_clk | output | 1 | Divided module clock |
| mb_id_sel | output | 1 | Identification space strobe |
| mb_io_sel | output | 1 | I/O space strobe |
| mb_int_sel | output | 1 | Interrupt-select strobe |
| mb_we | output | 1 | Write direction during a strobe |
| mb_addr | output | 7 | Word address |
| mb_be | output | 2 | Byte lane enables |
| mb_wdata | output | 16 | Write data for the current cycle |
| mb_rdata | input | 16 | Read data from the module |
| mb_rdrive | input | 16 | Per-bit mask of lines the module drives |
| mb_ack | input | 1 | Module acknowledge |

## Verification
The access path is tried in each of the three spaces with half, byte and word sizes. This separates strobe decoding, address masking per window and lane selection from one another. Reads use modules answering with zero, three and two hundred wait states, and also a module that never answers. These show the tick-paced sampling, the per-cycle restart of the timeout and the clean abort that issues no second half. A partially driven read bus shows the pull-up behaviour. A request raised in the middle of a split access shows that the block only listens when idle.

// File: rtl/mezz_pkg.sv
package mezz_pkg;
    typedef enum logic [1:0] {SP_ID = 2'd0, SP_IO = 2'd1, SP_INT = 2'd2} space_e;
    typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_HALF = 2'd1, SZ_WORD = 2'd2} size_e;
    typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_GAP = 2'd1, ST_STROBE = 2'd2} seq_state_e;
endpackage

// File: rtl/mezz_tick_gen.sv
module mezz_tick_gen #(
    parameter int DIV = 25
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick,
    output logic mod_clk
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);
    localparam logic [CW-1:0] HALF = CW'(DIV / 2);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          clk_lvl;
    } div_t;

    div_t div_d, div_q;

    always_comb begin
        div_d.cnt     = (div_q.cnt == LAST) ? '0 : div_q.cnt + 1'b1;
        div_d.clk_lvl = (div_d.cnt < HALF);
        tick          = (div_q.cnt == LAST);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q.cnt     <= '0;
            div_q.clk_lvl <= 1'b1;
        end else begin
            div_q <= div_d;
        end
    end

    assign mod_clk = div_q.clk_lvl;

    assert_cnt_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
        div_q.cnt <= LAST);

    generate
        if (DIV > 1) begin : g_spaced
            assert_tick_spaced_R10: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate
endmodule

// File: rtl/mezz_timeout.sv
module mezz_timeout #(
    parameter int LIMIT = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (!run)      cnt_d = '0;
        else if (tick) cnt_d = cnt_q + 1'b1;
        else           cnt_d = cnt_q;
        expired = run && tick && (cnt_q == LAST);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assert_count_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q <= LAST));

    assert_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run) |-> (cnt_q == '0));
endmodule

// File: rtl/mezz_access_seq.sv
module mezz_access_seq
    import mezz_pkg::*;
#(
    parameter int CLK_DIV       = 25,
    parameter int TIMEOUT_TICKS = 256,
    parameter int ADDR_W        = 8,
    parameter int ID_AW         = 6,
    parameter int BUS_W         = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [1:0]        req_space,
    input  logic [1:0]        req_size,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [2*BUS_W-1:0] req_wdata,
    output logic              rsp_done,
    output logic              rsp_timeout,
    output logic [2*BUS_W-1:0] rsp_rdata,
    output logic              mb_clk,
    output logic              mb_id_sel,
    output logic              mb_io_sel,
    output logic              mb_int_sel,
    output logic              mb_we,
    output logic [ADDR_W-2:0] mb_addr,
    output logic [1:0]        mb_be,
    output logic [BUS_W-1:0]  mb_wdata,
    input  logic [BUS_W-1:0]  mb_rdata,
    input  logic [BUS_W-1:0]  mb_rdrive,
    input  logic              mb_ack
);
    localparam int WA_W   = ADDR_W - 1;
    localparam int HOST_W = 2 * BUS_W;
    localparam int LANE_W = BUS_W / 2;

    typedef struct packed {
        seq_state_e        state;
        logic              half;
        space_e            space;
        logic              write;
        size_e             size;
        logic [WA_W-1:0]   waddr;
        logic [1:0]        be;
        logic [HOST_W-1:0] wdata;
        logic [HOST_W-1:0] rdata;
        logic              done;
        logic              tout;
    } seq_t;

    seq_t s_d, s_q;

    logic             tick;
    logic             expired;
    logic             strobe_on;
    logic [BUS_W-1:0] bus_word;
    space_e           sp_dec;
    logic [WA_W-1:0]  wa_dec;

    mezz_tick_gen #(.DIV(CLK_DIV)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .mod_clk (mb_clk)
    );

    mezz_timeout #(.LIMIT(TIMEOUT_TICKS)) u_tmo (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (strobe_on),
        .tick    (tick),
        .expired (expired)
    );

    assign strobe_on = (s_q.state == ST_STROBE);
    assign bus_word  = mb_rdata | ~mb_rdrive;

    always_comb begin
        case (req_space)
            2'd0:    sp_dec = SP_ID;
            2'd2:    sp_dec = SP_INT;
            default: sp_dec = SP_IO;
        endcase
        case (sp_dec)
            SP_ID:   wa_dec = WA_W'(req_addr[ID_AW-1:1]);
            SP_INT:  wa_dec = WA_W'(req_addr[1]);
            default: wa_dec = req_addr[ADDR_W-1:1];
        endcase
    end

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        case (s_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    s_d.state = ST_GAP;
                    s_d.half  = 1'b0;
                    s_d.space = sp_dec;
                    s_d.write = req_write;
                    s_d.size  = size_e'(req_size);
                    s_d.waddr = wa_dec;
                    s_d.wdata = req_wdata;
                    s_d.rdata = '0;
                    s_d.tout  = 1'b0;
                    if (sp_dec != SP_ID && req_size == SZ_BYTE)
                        s_d.be = req_addr[0] ? 2'b10 : 2'b01;
                    else
                        s_d.be = 2'b11;
                end
            end
            ST_GAP: begin
                if (tick) s_d.state = ST_STROBE;
            end
            ST_STROBE: begin
                if (tick && mb_ack) begin
                    if (!s_q.write) begin
                        if (s_q.size == SZ_WORD) begin
                            if (s_q.half) s_d.rdata[HOST_W-1:BUS_W] = bus_word;
                            else          s_d.rdata[BUS_W-1:0]      = bus_word;
                        end else if (s_q.size == SZ_BYTE && s_q.space != SP_ID) begin
                            s_d.rdata = HOST_W'(s_q.be[1] ? bus_word[BUS_W-1:LANE_W]
                                                          : bus_word[LANE_W-1:0]);
                        end else begin
                            s_d.rdata = HOST_W'(bus_word);
                        end
                    end
                    if (s_q.size == SZ_WORD && !s_q.half) begin
                        s_d.half  = 1'b1;
                        s_d.waddr = s_q.waddr + 1'b1;
                        s_d.state = ST_GAP;
                    end else begin
                        s_d.state = ST_IDLE;
                        s_d.done  = 1'b1;
                    end
                end else if (expired) begin
                    s_d.rdata = '1;
                    s_d.tout  = 1'b1;
                    s_d.state = ST_IDLE;
                    s_d.done  = 1'b1;
                end
            end
            default: s_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.state <= ST_IDLE;
            s_q.half  <= 1'b0;
            s_q.space <= SP_IO;
            s_q.write <= 1'b0;
            s_q.size  <= SZ_HALF;
            s_q.waddr <= '0;
            s_q.be    <= 2'b00;
            s_q.wdata <= '0;
            s_q.rdata <= '0;
            s_q.done  <= 1'b0;
            s_q.tout  <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign req_ready   = (s_q.state == ST_IDLE);
    assign rsp_done    = s_q.done;
    assign rsp_timeout = s_q.tout;
    assign rsp_rdata   = s_q.rdata;
    assign mb_id_sel   = strobe_on && (s_q.space == SP_ID);
    assign mb_io_sel   = strobe_on && (s_q.space == SP_IO);
    assign mb_int_sel  = strobe_on && (s_q.space == SP_INT);
    assign mb_we       = strobe_on && s_q.write;
    assign mb_addr     = s_q.waddr;
    assign mb_be       = strobe_on ? s_q.be : 2'b00;
    assign mb_wdata    = s_q.half ? s_q.wdata[HOST_W-1:BUS_W] : s_q.wdata[BUS_W-1:0];

    logic any_sel;
    assign any_sel = mb_id_sel | mb_io_sel | mb_int_sel;

    assert_one_sel_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mb_id_sel, mb_io_sel, mb_int_sel}));

    assert_int_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mb_int_sel |-> (mb_addr[WA_W-1:1] == '0));

    assert_id_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mb_id_sel |-> (mb_be == 2'b11));

    assert_tout_ones_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_done && rsp_timeout) |-> (rsp_rdata == '1));

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !any_sel);

    assert_fall_on_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(any_sel) |-> $past(tick));
endmodule

// File: tb/mezz_access_seq_test.sv
module mezz_access_seq_test;
    localparam int DIV  = 25;
    localparam int TMO  = 256;
    localparam int WAIT_LIMIT = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [1:0]  req_space = 2'd1;
    logic [1:0]  req_size = 2'd1;
    logic [7:0]  req_addr = 8'h00;
    logic [31:0] req_wdata = 32'h0;
    logic        rsp_done, rsp_timeout;
    logic [31:0] rsp_rdata;
    logic        mb_clk, mb_id_sel, mb_io_sel, mb_int_sel, mb_we;
    logic [6:0]  mb_addr;
    logic [1:0]  mb_be;
    logic [15:0] mb_wdata;
    logic [15:0] mb_rdata;
    logic [15:0] mb_rdrive = 16'hFFFF;
    logic        mb_ack;

    logic        ack_en = 1'b1;
    int          ack_dly = 0;
    logic [15:0] resp_lo = 16'h0, resp_hi = 16'h0;

    int          scount = 0;
    int          age = 0;
    logic        prev_any = 1'b0;
    logic [6:0]  cap_addr [2];
    logic [1:0]  cap_be   [2];
    logic        cap_we   [2];
    logic [15:0] cap_wd   [2];
    int          cap_sp   [2];

    int          n_checks = 0, n_errors = 0;
    logic [31:0] res_rdata;
    logic        res_tout;
    int          res_cycles;

    always #2.5 clk = ~clk;

    mezz_access_seq uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_space(req_space), .req_size(req_size),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_done(rsp_done),
        .rsp_timeout(rsp_timeout), .rsp_rdata(rsp_rdata), .mb_clk(mb_clk),
        .mb_id_sel(mb_id_sel), .mb_io_sel(mb_io_sel), .mb_int_sel(mb_int_sel),
        .mb_we(mb_we), .mb_addr(mb_addr), .mb_be(mb_be), .mb_wdata(mb_wdata),
        .mb_rdata(mb_rdata), .mb_rdrive(mb_rdrive), .mb_ack(mb_ack)
    );

    logic any_sel;
    assign any_sel  = mb_id_sel | mb_io_sel | mb_int_sel;
    assign mb_ack   = any_sel && ack_en && (age >= ack_dly);
    assign mb_rdata = (scount >= 2) ? resp_hi : resp_lo;

    always @(posedge clk) begin
        prev_any <= any_sel;
        age      <= (any_sel && prev_any) ? age + 1 : 0;
        if (req_valid && req_ready) begin
            scount <= 0;
        end else if (any_sel && !prev_any) begin
            if (scount < 2) begin
                cap_addr[scount] <= mb_addr;
                cap_be[scount]   <= mb_be;
                cap_we[scount]   <= mb_we;
                cap_wd[scount]   <= mb_wdata;
                cap_sp[scount]   <= mb_id_sel ? 0 : (mb_io_sel ? 1 : 2);
            end
            scount <= scount + 1;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic chk_range(input string tag, input int act, input int lo, input int hi);
        n_checks++;
        if (act < lo || act > hi) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d..%0d", tag, act, lo, hi);
        end
    endtask

    task automatic access(input logic [1:0] sp, input logic wr, input logic [1:0] sz,
                          input logic [7:0] addr, input logic [31:0] wd, input bit intrude);
        int cyc;
        @(negedge clk);
        req_space = sp; req_write = wr; req_size = sz; req_addr = addr; req_wdata = wd;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        cyc = 1;
        while (!rsp_done && cyc < WAIT_LIMIT) begin
            if (intrude && cyc == 40) begin
                req_space = 2'd2; req_size = 2'd1; req_addr = 8'h02; req_valid = 1'b1;
            end
            if (intrude && cyc == 60) req_valid = 1'b0;
            @(negedge clk);
            cyc++;
        end
        req_valid = 1'b0;
        if (!rsp_done) begin
            n_checks++; n_errors++;
            $display("FAIL watchdog R9: actual no done expected done");
        end
        res_rdata  = rsp_rdata;
        res_tout   = rsp_timeout;
        res_cycles = cyc;
        @(negedge clk);
        chk("R9 done width", {31'b0, rsp_done}, 32'h0);
    endtask

    task automatic t_reset;
        chk("R1 ready", {31'b0, req_ready}, 32'h1);
        chk("R1 done", {31'b0, rsp_done}, 32'h0);
        chk("R1 strobes", {29'b0, mb_id_sel, mb_io_sel, mb_int_sel}, 32'h0);
    endtask

    task automatic t_io_half;
        ack_en = 1; ack_dly = 0; mb_rdrive = 16'hFFFF; resp_lo = 16'hBEEF;
        access(2'd1, 1'b0, 2'd1, 8'h36, 32'h0, 0);
        chk("R2 io strobe", cap_sp[0], 1);
        chk("R3 io addr", {25'b0, cap_addr[0]}, 32'h1B);
        chk("R4 half be", {30'b0, cap_be[0]}, 32'h3);
        chk("R11 half read", res_rdata, 32'h0000BEEF);
        chk("R7 no tout", {31'b0, res_tout}, 32'h0);
        chk("R2 one cycle", scount, 1);
    endtask

    task automatic t_bytes;
        access(2'd1, 1'b1, 2'd0, 8'h45, 32'h0000A500, 0);
        chk("R4 odd byte be", {30'b0, cap_be[0]}, 32'h2);
        chk("R4 write dir", {31'b0, cap_we[0]}, 32'h1);
        chk("R3 byte addr", {25'b0, cap_addr[0]}, 32'h22);
        chk("R5 byte wdata", {16'b0, cap_wd[0]}, 32'hA500);
        resp_lo = 16'h12C3;
        access(2'd1, 1'b0, 2'd0, 8'h44, 32'h0, 0);
        chk("R4 even byte be", {30'b0, cap_be[0]}, 32'h1);
        chk("R11 low lane", res_rdata, 32'h000000C3);
        access(2'd1, 1'b0, 2'd0, 8'h45, 32'h0, 0);
        chk("R11 high lane", res_rdata, 32'h00000012);
    endtask

    task automatic t_id_int;
        resp_lo = 16'h5A17;
        access(2'd0, 1'b0, 2'd0, 8'hFF, 32'h0, 0);
        chk("R2 id strobe", cap_sp[0], 0);
        chk("R3 id masked addr", {25'b0, cap_addr[0]}, 32'h1F);
        chk("R4 id full be", {30'b0, cap_be[0]}, 32'h3);
        chk("R4 id word read", res_rdata, 32'h00005A17);
        access(2'd2, 1'b0, 2'd1, 8'hFE, 32'h0, 0);
        chk("R2 int strobe", cap_sp[0], 2);
        chk("R3 int line1", {25'b0, cap_addr[0]}, 32'h1);
        access(2'd2, 1'b0, 2'd1, 8'hFC, 32'h0, 0);
        chk("R3 int line0", {25'b0, cap_addr[0]}, 32'h0);
        access(2'd3, 1'b0, 2'd1, 8'h02, 32'h0, 0);
        chk("R2 code3 io", cap_sp[0], 1);
    endtask

    task automatic t_split;
        resp_lo = 16'h1111; resp_hi = 16'h2222;
        access(2'd1, 1'b0, 2'd2, 8'h10, 32'h0, 0);
        chk("R5 two cycles", scount, 2);
        chk("R5 first addr", {25'b0, cap_addr[0]}, 32'h08);
        chk("R5 second addr", {25'b0, cap_addr[1]}, 32'h09);
        chk("R5 read join", res_rdata, 32'h22221111);
        access(2'd1, 1'b1, 2'd2, 8'h20, 32'hCAFE0123, 0);
        chk("R5 wdata low", {16'b0, cap_wd[0]}, 32'h0123);
        chk("R5 wdata high", {16'b0, cap_wd[1]}, 32'hCAFE);
    endtask

    task automatic t_undriven;
        mb_rdrive = 16'h00FF; resp_lo = 16'h1234;
        access(2'd1, 1'b0, 2'd1, 8'h00, 32'h0, 0);
        chk("R6 pull ones", res_rdata, 32'h0000FF34);
        mb_rdrive = 16'hFFFF;
    endtask

    task automatic t_timeout;
        ack_en = 0;
        access(2'd1, 1'b0, 2'd1, 8'h08, 32'h0, 0);
        chk("R7 tout flag", {31'b0, res_tout}, 32'h1);
        chk("R7 tout data", res_rdata, 32'hFFFFFFFF);
        chk_range("R7 tout time", res_cycles, TMO * DIV, (TMO + 1) * DIV + 4);
        access(2'd1, 1'b0, 2'd2, 8'h08, 32'h0, 0);
        chk("R7 no second half", scount, 1);
        chk("R7 split tout", {31'b0, res_tout}, 32'h1);
        ack_en = 1;
    endtask

    task automatic t_restart;
        ack_dly = 200 * DIV; resp_lo = 16'hAAAA; resp_hi = 16'h5555;
        access(2'd1, 1'b0, 2'd2, 8'h30, 32'h0, 0);
        chk("R8 long split ok", {31'b0, res_tout}, 32'h0);
        chk("R8 long split data", res_rdata, 32'h5555AAAA);
        ack_dly = 0;
    endtask

    task automatic t_waits_and_busy;
        int c0, c3;
        resp_lo = 16'h0F0F;
        access(2'd1, 1'b0, 2'd1, 8'h04, 32'h0, 0);
        c0 = res_cycles;
        ack_dly = 3 * DIV;
        access(2'd1, 1'b0, 2'd1, 8'h04, 32'h0, 0);
        c3 = res_cycles;
        chk_range("R10 wait cost", c3 - c0, 2 * DIV, 4 * DIV);
        ack_dly = 2 * DIV; resp_lo = 16'h7777; resp_hi = 16'h8888;
        access(2'd1, 1'b0, 2'd2, 8'h40, 32'h0, 1);
        chk("R9 busy ignored count", scount, 2);
        chk("R9 busy ignored space", cap_sp[1], 1);
        chk("R9 busy data", res_rdata, 32'h88887777);
        chk("R9 idle after", {31'b0, req_ready}, 32'h1);
        ack_dly = 0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_io_half();
        t_bytes();
        t_id_int();
        t_split();
        t_undriven();
        t_timeout();
        t_restart();
        t_waits_and_busy();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_checks++; n_errors++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule